// File: doc/BRIEF.md
# Fuse-Backed Configuration Store with Shadow Register

This block keeps a 46-bit configuration word in a one-time-programmable fuse array and works from a shadow copy of it. At reset the shadow is filled from the fuses. The user fields of the shadow drive the rest of the chip: sensor bias, offset select, amplifier gain, the common-mode selects and the channel inversion. A serial front end has already decoded each access into a 5-bit command code and a data word. Those accesses reach this block as a valid/ready stream.

Two short commands exist. A configuration write carries a sleep request and a general reset request. An unlock command opens the long commands. There are three long commands: load the shadow, burn the shadow into the fuses, and stream the shadow back out one bit per beat, starting with the most significant bit. The long commands are refused until an unlock has been accepted. User commands can never alter bits 16 to 45, which hold factory trim. A lock bit guards the reserved bits next to the user field. Each fuse can only go from 0 to 1. A burn gives a one-cycle pulse.

Stream rules:
- A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high.
- `cmd_ready_o` is low from the acceptance of a readback until its final beat has been taken.
- A readback beat is taken on an edge where `rd_valid_o` and `rd_ready_i` are both high.
- While the consumer holds `rd_ready_i` low, `rd_bit_o` and `rd_last_o` do not change.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset the shadow equals the fuse power-on value `FUSE_INIT`. `sleep_o` is 0, `rd_valid_o` is 0, `cmd_ready_o` is 1, and the block is not unlocked.
- R2: The field outputs map to these shadow bits: `hall_bias_o`=[5:0], `dc_offset_o`=[6], `gain_o`=[8:7], `cm_cos_o`=[9], `cm_sin_o`=[10], `invert_o`=[11], `lock_o`=[13]. A shadow change shows on them in the cycle after the command is accepted.
- R3: The codes 11111 (load), 11001 (burn) and 01111 (readback) are accepted but have no effect unless code 10000 (unlock) was accepted after the last reset or general reset. A refused readback gives no beats, and a refused burn gives no pulse.
- R4: A load (11111) always copies data bits [11:0] into the shadow. It copies bits [15:12] only if shadow bit 13 is 0 before the load. Bits [45:16] never change.
- R5: A burn (11001) ORs shadow bits [15:0] into the fuses and never clears a fuse. `burn_pulse_o` is high for exactly the cycle after the burn is accepted.
- R6: A readback (01111) gives 46 beats, shadow bit 45 first and bit 0 last. `rd_last_o` is high only on the final beat. Under back-pressure the beat is held.
- R7: A configuration write (10111) with data bit 14 set is a general reset. It reloads the shadow from the fuses, clears the unlock and clears sleep. If bit 14 is clear, data bit 15 sets `sleep_o`. While `sleep_o` is 1, all field outputs read 0.
- R8: Any other command code is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_code_i | input | 5 | Decoded command code |
| cmd_data_i | input | 46 | Command data; short commands use [15:0] |
| rd_valid_o | output | 1 | Readback beat present |
| rd_ready_i | input | 1 | Consumer takes the beat |
| rd_bit_o | output | 1 | Readback bit |
| rd_last_o | output | 1 | Final readback beat |
| burn_pulse_o | output | 1 | One-cycle fuse burn strobe |
| sleep_o | output | 1 | Low-power request, outputs removed |
| hall_bias_o | output | 6 | Sensor bias field |
| dc_offset_o | output | 1 | Output offset select |
| gain_o | output | 2 | Amplifier gain field |
| cm_cos_o | output | 1 | Cosine common-mode select |
| cm_sin_o | output | 1 | Sine common-mode select |
| invert_o | output | 1 | Channel inversion |
| lock_o | output | 1 | Lock bit |

## Verification
The bench sweeps all 4096 user-field values through the load path and compares the field outputs against arithmetic slices of a bench model. A design that swapped or shifted a field would fail here. Readbacks run with and without stalls. A design that sent the bits LSB first, flagged the last beat early, or let the bit slip during a stall would be caught. The corner cases are:
- long commands sent before unlock and after a general reset, where a leaky gate would change the shadow or the fuses;
- loads of the reserved nibble before and after the lock bit is set;
- a burn of all zeros after a burn of ones, which a design that overwrites fuses instead of ORing would get wrong;
- sleep blanking, where the field outputs must read 0.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [4:0] {
    CMD_CFG    = 5'b10111,
    CMD_UNLOCK = 5'b10000,
    CMD_LOAD   = 5'b11111,
    CMD_BURN   = 5'b11001,
    CMD_READ   = 5'b01111
  } otp_cmd_e;

  typedef struct packed {
    logic cfg;
    logic unlock;
    logic load;
    logic burn;
    logic read;
  } otp_act_t;
endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_pkg::*;
(
  input  logic       fire_i,
  input  logic [4:0] code_i,
  input  logic       unlocked_i,
  output otp_act_t   act_o
);
  always_comb begin
    act_o = '0;
    if (fire_i) begin
      case (code_i)
        CMD_CFG:    act_o.cfg    = 1'b1;
        CMD_UNLOCK: act_o.unlock = 1'b1;
        CMD_LOAD:   act_o.load   = unlocked_i;
        CMD_BURN:   act_o.burn   = unlocked_i;
        CMD_READ:   act_o.read   = unlocked_i;
        default:    act_o        = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int W = 46,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         burn_i,
  input  logic [W-1:0] burn_bits_i,
  output logic [W-1:0] fuse_o,
  output logic         burn_pulse_o
);
  for (genvar g = 0; g < W; g++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cell_q <= INIT[g];
      else if (burn_i && burn_bits_i[g]) cell_q <= 1'b1;
    end
    assign fuse_o[g] = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burn_pulse_o <= 1'b0;
    else        burn_pulse_o <= burn_i;
  end

  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fuse_o) & ~fuse_o) == '0)); // R5
endmodule

// File: rtl/otp_rd_ser.sv
module otp_rd_ser #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_bits_i,
  output logic         rd_valid_o,
  input  logic         rd_ready_i,
  output logic         rd_bit_o,
  output logic         rd_last_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] left_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        sh_q   <= load_bits_i;
        left_q <= CW'(W - 1);
        busy_q <= 1'b1;
      end
    end else if (rd_ready_i) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign rd_valid_o = busy_q;
  assign rd_bit_o   = sh_q[W-1];
  assign rd_last_o  = busy_q && (left_q == '0);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_bit_o) && $stable(rd_last_o))); // R6
endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_pkg::*;
#(
  parameter int W = 46,
  parameter int USER_W = 12,
  parameter int GUARD_W = 16,
  parameter int LOCK_BIT = 13,
  parameter int SLEEP_BIT = 15,
  parameter int GRST_BIT = 14,
  parameter logic [W-1:0] FUSE_INIT = 46'h1234_5678_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid_i,
  output logic         cmd_ready_o,
  input  logic [4:0]   cmd_code_i,
  input  logic [W-1:0] cmd_data_i,
  output logic         rd_valid_o,
  input  logic         rd_ready_i,
  output logic         rd_bit_o,
  output logic         rd_last_o,
  output logic         burn_pulse_o,
  output logic         sleep_o,
  output logic [5:0]   hall_bias_o,
  output logic         dc_offset_o,
  output logic [1:0]   gain_o,
  output logic         cm_cos_o,
  output logic         cm_sin_o,
  output logic         invert_o,
  output logic         lock_o
);
  localparam logic [W-1:0] USER_MASK  = {{(W-USER_W){1'b0}}, {USER_W{1'b1}}};
  localparam logic [W-1:0] GUARD_MASK = {{(W-GUARD_W){1'b0}}, {GUARD_W{1'b1}}};

  logic [W-1:0] shadow_q, fuse_w, wmask, vis;
  logic         unlock_q, sleep_q, fire;
  otp_act_t     act;

  assign fire = cmd_valid_i && cmd_ready_o;

  otp_cmd_decode u_dec (
    .fire_i     (fire),
    .code_i     (cmd_code_i),
    .unlocked_i (unlock_q),
    .act_o      (act)
  );

  otp_fuse_array #(.W(W), .INIT(FUSE_INIT)) u_fuse (
    .clk          (clk),
    .rst_n        (rst_n),
    .burn_i       (act.burn),
    .burn_bits_i  (shadow_q & GUARD_MASK),
    .fuse_o       (fuse_w),
    .burn_pulse_o (burn_pulse_o)
  );

  otp_rd_ser #(.W(W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (act.read),
    .load_bits_i (shadow_q),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready_i),
    .rd_bit_o    (rd_bit_o),
    .rd_last_o   (rd_last_o)
  );

  assign cmd_ready_o = !rd_valid_o;
  assign wmask = shadow_q[LOCK_BIT] ? USER_MASK : GUARD_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= FUSE_INIT;
      unlock_q <= 1'b0;
      sleep_q  <= 1'b0;
    end else begin
      if (act.unlock) unlock_q <= 1'b1;
      if (act.load)   shadow_q <= (shadow_q & ~wmask) | (cmd_data_i & wmask);
      if (act.cfg) begin
        if (cmd_data_i[GRST_BIT]) begin
          shadow_q <= fuse_w;
          unlock_q <= 1'b0;
          sleep_q  <= 1'b0;
        end else begin
          sleep_q  <= cmd_data_i[SLEEP_BIT];
        end
      end
    end
  end

  assign vis         = sleep_q ? '0 : shadow_q;
  assign sleep_o     = sleep_q;
  assign hall_bias_o = vis[5:0];
  assign dc_offset_o = vis[6];
  assign gain_o      = vis[8:7];
  assign cm_cos_o    = vis[9];
  assign cm_sin_o    = vis[10];
  assign invert_o    = vis[11];
  assign lock_o      = vis[LOCK_BIT];

  AST_FACTORY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(shadow_q[W-1:GUARD_W])); // R4
  AST_LOCK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q[LOCK_BIT] && !act.cfg) |=> $stable(shadow_q[GUARD_W-1:USER_W])); // R4
  AST_BURN_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    burn_pulse_o |-> $past(unlock_q)); // R3
  AST_GRST_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (act.cfg && cmd_data_i[GRST_BIT]) |=> (!sleep_o && !unlock_q)); // R7
endmodule

// File: tb/otp_shadow_ctrl_tb_top.sv
module otp_shadow_ctrl_tb_top;
  localparam logic [45:0] INIT = 46'h1234_5678_0000;
  localparam logic [4:0] C_CFG = 5'b10111, C_UNL = 5'b10000, C_LOAD = 5'b11111,
                         C_BURN = 5'b11001, C_READ = 5'b01111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rd_ready = 1'b0;
  logic [4:0] cmd_code = '0;
  logic [45:0] cmd_data = '0;
  logic cmd_ready, rd_valid, rd_bit, rd_last, burn_pulse, sleep;
  logic [5:0] hall; logic dco, cmc, cms, inv, lck; logic [1:0] gain;

  int total = 0, bad = 0, cyc = 0;
  logic [45:0] m_sh = INIT, m_fuse = INIT;
  bit m_sleep = 1'b0;

  always #5 clk = ~clk;

  otp_shadow_ctrl #(.FUSE_INIT(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_code_i(cmd_code), .cmd_data_i(cmd_data), .rd_valid_o(rd_valid),
    .rd_ready_i(rd_ready), .rd_bit_o(rd_bit), .rd_last_o(rd_last),
    .burn_pulse_o(burn_pulse), .sleep_o(sleep), .hall_bias_o(hall),
    .dc_offset_o(dco), .gain_o(gain), .cm_cos_o(cmc), .cm_sin_o(cms),
    .invert_o(inv), .lock_o(lck));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_fields();
    if (m_sleep) return '0;
    return {m_sh[13], m_sh[11], m_sh[10], m_sh[9], m_sh[8:7], m_sh[6], m_sh[5:0]};
  endfunction

  task automatic chk_fields(input string req);
    logic [12:0] a;
    a = {lck, inv, cms, cmc, gain, dco, hall};
    chk(a == exp_fields(), req, 64'(a), 64'(exp_fields()));
  endtask

  task automatic send(input logic [4:0] c, input logic [45:0] d);
    @(negedge clk);
    cmd_code = c; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic void m_load(input logic [45:0] d);
    logic [45:0] mk;
    mk = m_sh[13] ? 46'hFFF : 46'hFFFF;
    m_sh = (m_sh & ~mk) | (d & mk);
  endfunction

  task automatic readback(input int stall, input string req);
    logic [45:0] v = '0;
    int beats = 0;
    bit last_ok = 1'b1, hold_ok = 1'b1, held = 1'b0;
    logic hb = 1'b0;
    send(C_READ, '0);
    for (int g = 0; g < 400 && beats < 46; g++) begin
      if (held && rd_bit != hb) hold_ok = 1'b0;
      rd_ready = (stall == 0) || ((g % stall) != 0);
      held = 1'b0;
      if (rd_valid && rd_ready) begin
        v[45-beats] = rd_bit;
        if (rd_last != (beats == 45)) last_ok = 1'b0;
        beats++;
      end else if (rd_valid) begin
        held = 1'b1; hb = rd_bit;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk(v == m_sh, {req, " R6 data"}, 64'(v), 64'(m_sh));
    chk(last_ok && beats == 46, "R6 last flag", 64'(beats), 64'd46);
    chk(hold_ok, "R6 hold under stall", 64'(hold_ok), 64'd1);
    chk(!rd_valid && cmd_ready, "R6 idle after", 64'({rd_valid, cmd_ready}), 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sleep == 0 && rd_valid == 0 && cmd_ready == 1, "R1 status", 64'({sleep, rd_valid, cmd_ready}), 64'b001);
    chk_fields("R1 fields");
    // R3 locked out before unlock
    send(C_LOAD, {46{1'b1}});
    chk_fields("R3 load refused");
    send(C_BURN, '0);
    chk(burn_pulse == 0, "R3 burn refused", 64'(burn_pulse), 64'd0);
    send(C_READ, '0);
    for (int k = 0; k < 4; k++) begin
      chk(rd_valid == 0, "R3 read refused", 64'(rd_valid), 64'd0);
      @(negedge clk);
    end
    // R2 / R4 sweep of all user values
    send(C_UNL, '0);
    for (int v = 0; v < 4096; v++) begin
      send(C_LOAD, {30'h3FFFFFFF, 4'h0, 12'(v)});
      m_load({30'h3FFFFFFF, 4'h0, 12'(v)});
      chk_fields("R2 R4 sweep");
    end
    readback(0, "R4 factory kept");
    send(C_LOAD, 46'h0000_0000_5A5C);
    m_load(46'h0000_0000_5A5C);
    readback(3, "R4 reserved open");
    // R5 burn
    send(C_BURN, '0);
    chk(burn_pulse == 1, "R5 pulse high", 64'(burn_pulse), 64'd1);
    @(negedge clk);
    chk(burn_pulse == 0, "R5 pulse one cycle", 64'(burn_pulse), 64'd0);
    m_fuse = m_fuse | (m_sh & 46'hFFFF);
    send(C_LOAD, '0); m_load('0);
    // R7 general reset reloads fuses
    send(C_CFG, 46'h4000);
    m_sh = m_fuse;
    chk_fields("R7 reload");
    send(C_LOAD, 46'h0FFF);
    chk_fields("R7 unlock cleared");
    send(C_UNL, '0);
    readback(2, "R5 fuse value");
    // R5 no clear
    send(C_LOAD, '0); m_load('0);
    send(C_BURN, '0);
    send(C_CFG, 46'h4000); m_sh = m_fuse;
    send(C_UNL, '0);
    readback(0, "R5 no clear");
    // R4 lock guard
    send(C_LOAD, 46'h2003); m_load(46'h2003);
    chk(lck == 1, "R4 lock set", 64'(lck), 64'd1);
    send(C_LOAD, 46'hDFFF); m_load(46'hDFFF);
    readback(4, "R4 locked nibble");
    // R7 sleep
    send(C_CFG, 46'h8000); m_sleep = 1'b1;
    chk(sleep == 1, "R7 sleep on", 64'(sleep), 64'd1);
    chk_fields("R7 blank");
    send(C_CFG, 46'h0000); m_sleep = 1'b0;
    chk(sleep == 0, "R7 sleep off", 64'(sleep), 64'd0);
    chk_fields("R7 restored");
    // R8 unknown code
    send(5'b00011, {46{1'b1}});
    chk_fields("R8 no effect");
    chk(sleep == 0 && burn_pulse == 0, "R8 status", 64'({sleep, burn_pulse}), 64'd0);
    readback(0, "R8 shadow kept");
    // R7 general reset overrides sleep
    send(C_CFG, 46'h8000); m_sleep = 1'b1;
    send(C_CFG, 46'hC000); m_sleep = 1'b0; m_sh = m_fuse;
    chk(sleep == 0, "R7 grst wakes", 64'(sleep), 64'd0);
    chk_fields("R7 grst fields");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cyc++;
endmodule